// File: doc/BRIEF.md
# Interrupting GPIO Controller

This block controls a bank of general purpose pins from a plain 32-bit register bus. Each pin can be driven from an output data bit. The drive passes through an optional inversion and is gated by a per-pin output enable. The block works out the level each pin actually settles to. A driver outside the chip takes precedence over the internal drive, and the internal drive takes precedence over the pull-up setting. The level is then sampled through a per-pin input enable.

On every clock edge the sampled value is registered. Four sticky pending flags per pin follow it: level high, level low, rising edge and falling edge. Software clears a flag by writing 1 to its bit. A per-pin interrupt line is raised whenever any pending flag of that pin is set together with its matching enable. Drive-strength and two alternate-function registers are kept for software but do not affect the pins. A per-pin short-circuit output reports an outside driver meeting an enabled internal driver.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The internal drive of a pin is `out_en & (out_bit ^ out_inv)`. With the output enabled and no external driver, `pin_level` equals that value.
- R2: `pin_level` equals `ext_value` when `ext_valid` is 1. Otherwise it equals the internal drive when the output is enabled, and otherwise the pull-up bit.
- R3: The value register (offset 0x00) reads `in_en & pin_level` as it stood at the previous clock edge. Writes to it are ignored.
- R4: On each edge, a pin's high flag is set if its new sampled value is 1, and its low flag is set if that value is 0.
- R5: A rise flag is set when the sampled value goes from 0 to 1 between edges. A fall flag is set when it goes from 1 to 0.
- R6: Pending flags stay set until cleared. Writing the pending registers (rise 0x1C, fall 0x24, high 0x2C, low 0x34) clears the bits written 1 and leaves the bits written 0 unchanged.
- R7: When a clear write and a new set condition hit the same bit in the same cycle, the flag ends up set.
- R8: `irq` per pin is the OR of rise, fall, high and low pending, each ANDed with its enable (0x18, 0x20, 0x28, 0x30).
- R9: Reset clears every register, so all reads return 0. Once reset is released with inputs disabled, the low flags read all ones.
- R10: `short_circuit` per pin is 1 exactly when `ext_valid` and the output enable are both 1.
- R11: The read/write registers read back what was last written. They are input enable 0x04, output enable 0x08, output data 0x0C, pull-up 0x10, drive strength 0x14, the interrupt enables, alternate enable 0x38, alternate select 0x3C and output invert 0x40.
- R12: Reads at offsets above 0x40, or with address bits [1:0] nonzero, return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ext_valid | input | NPINS | Outside driver active per pin |
| ext_value | input | NPINS | Level applied by the outside driver |
| pin_level | output | NPINS | Resolved pin level |
| irq | output | NPINS | Per-pin interrupt |
| short_circuit | output | NPINS | Outside driver against enabled output |

## Verification
Two things can happen in the same cycle: a software write-1-to-clear to a pending register, and a change of the sampled input that sets the same flag. The bench arranges this by changing the external pin pattern in the same bus cycle as a clear of all rise flags. It then expects the rise register to hold exactly the bits that went from 0 to 1, so the set condition wins. Partial-mask clears are also checked, which shows that bits written 0 keep their state.

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] ext_valid,
  input  logic [NPINS-1:0] ext_value,
  output logic [NPINS-1:0] pin_level,
  output logic [NPINS-1:0] irq,
  output logic [NPINS-1:0] short_circuit
);
  localparam int WI = AW - 2;
  localparam logic [WI-1:0] R_VAL  = WI'(0);
  localparam logic [WI-1:0] R_IEN  = WI'(1);
  localparam logic [WI-1:0] R_OEN  = WI'(2);
  localparam logic [WI-1:0] R_OUT  = WI'(3);
  localparam logic [WI-1:0] R_PUE  = WI'(4);
  localparam logic [WI-1:0] R_DS   = WI'(5);
  localparam logic [WI-1:0] R_RIE  = WI'(6);
  localparam logic [WI-1:0] R_RIP  = WI'(7);
  localparam logic [WI-1:0] R_FIE  = WI'(8);
  localparam logic [WI-1:0] R_FIP  = WI'(9);
  localparam logic [WI-1:0] R_HIE  = WI'(10);
  localparam logic [WI-1:0] R_HIP  = WI'(11);
  localparam logic [WI-1:0] R_LIE  = WI'(12);
  localparam logic [WI-1:0] R_LIP  = WI'(13);
  localparam logic [WI-1:0] R_AFE  = WI'(14);
  localparam logic [WI-1:0] R_AFS  = WI'(15);
  localparam logic [WI-1:0] R_INV  = WI'(16);

  logic [NPINS-1:0] in_en, out_en, out_bit, pull_en, drive_str, out_inv;
  logic [NPINS-1:0] rise_en, fall_en, high_en, low_en, alt_en, alt_sel;
  logic [NPINS-1:0] rise_p, fall_p, high_p, low_p, sampled;

  wire [WI-1:0]    widx   = bus_addr[AW-1:2];
  wire             hit_ok = (bus_addr[1:0] == 2'b00);
  wire             wr     = bus_valid & bus_we & hit_ok;
  wire [NPINS-1:0] wd     = bus_wdata[NPINS-1:0];

  wire [NPINS-1:0] drive  = out_en & (out_bit ^ out_inv);
  assign pin_level     = (ext_valid & ext_value) | (~ext_valid & out_en & drive)
                       | (~ext_valid & ~out_en & pull_en);
  assign short_circuit = ext_valid & out_en;
  wire [NPINS-1:0] samp_n = in_en & pin_level;

  wire [NPINS-1:0] clr_r = (wr && widx == R_RIP) ? wd : '0;
  wire [NPINS-1:0] clr_f = (wr && widx == R_FIP) ? wd : '0;
  wire [NPINS-1:0] clr_h = (wr && widx == R_HIP) ? wd : '0;
  wire [NPINS-1:0] clr_l = (wr && widx == R_LIP) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en <= '0; out_en <= '0; out_bit <= '0; pull_en <= '0;
      drive_str <= '0; out_inv <= '0; alt_en <= '0; alt_sel <= '0;
      rise_en <= '0; fall_en <= '0; high_en <= '0; low_en <= '0;
    end else if (wr) begin
      case (widx)
        R_IEN: in_en     <= wd;
        R_OEN: out_en    <= wd;
        R_OUT: out_bit   <= wd;
        R_PUE: pull_en   <= wd;
        R_DS:  drive_str <= wd;
        R_RIE: rise_en   <= wd;
        R_FIE: fall_en   <= wd;
        R_HIE: high_en   <= wd;
        R_LIE: low_en    <= wd;
        R_AFE: alt_en    <= wd;
        R_AFS: alt_sel   <= wd;
        R_INV: out_inv   <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled <= '0; rise_p <= '0; fall_p <= '0; high_p <= '0; low_p <= '0;
    end else begin
      sampled <= samp_n;
      rise_p  <= (rise_p & ~clr_r) | (samp_n & ~sampled);
      fall_p  <= (fall_p & ~clr_f) | (~samp_n & sampled);
      high_p  <= (high_p & ~clr_h) | samp_n;
      low_p   <= (low_p  & ~clr_l) | ~samp_n;
    end
  end

  assign irq = (rise_p & rise_en) | (fall_p & fall_en) | (high_p & high_en) | (low_p & low_en);

  logic [NPINS-1:0] rsel;
  always_comb begin
    rsel = '0;
    if (bus_valid && !bus_we && hit_ok) begin
      case (widx)
        R_VAL: rsel = sampled;
        R_IEN: rsel = in_en;
        R_OEN: rsel = out_en;
        R_OUT: rsel = out_bit;
        R_PUE: rsel = pull_en;
        R_DS:  rsel = drive_str;
        R_RIE: rsel = rise_en;
        R_RIP: rsel = rise_p;
        R_FIE: rsel = fall_en;
        R_FIP: rsel = fall_p;
        R_HIE: rsel = high_en;
        R_HIP: rsel = high_p;
        R_LIE: rsel = low_en;
        R_LIP: rsel = low_p;
        R_AFE: rsel = alt_en;
        R_AFS: rsel = alt_sel;
        R_INV: rsel = out_inv;
        default: rsel = '0;
      endcase
    end
  end
  assign bus_rdata = 32'(rsel);

  p_level_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sampled & ~high_p) | (~sampled & ~low_p)) == '0);

  p_edge_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((sampled & ~$past(sampled)) & ~rise_p) |
               ((~sampled & $past(sampled)) & ~fall_p)) == '0);

  p_rise_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && widx == R_RIP) |=> ($past(rise_p) & ~rise_p) == '0);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en | fall_en | high_en | low_en) == '0) |-> irq == '0);

  p_unmapped_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && !hit_ok) |-> bus_rdata == '0);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_we = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] ext_valid = '0, ext_value = '0;
  logic [31:0] pin_level, irq, short_circuit;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(32), .AW(7)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_valid(ext_valid), .ext_value(ext_value), .pin_level(pin_level),
    .irq(irq), .short_circuit(short_circuit));

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    nvec++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = 7'(off); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input int off, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = 7'(off);
    #0.5;
    d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic edge_case(input logic [31:0] a, input logic [31:0] b, input logic [31:0] m);
    logic [31:0] d;
    @(negedge clk); ext_valid = '1; ext_value = a;
    @(negedge clk);
    wr(32'h1C, '1); wr(32'h24, '1); wr(32'h2C, '1); wr(32'h34, '1);
    rd(32'h2C, d); chk("R4 high after clear", d, a);
    rd(32'h34, d); chk("R4 low after clear", d, ~a);
    rd(32'h1C, d); chk("R6 rise cleared", d, 32'h0);
    // R7: pattern change and a full rise clear in the same cycle
    @(negedge clk);
    ext_value = b; bus_valid = 1; bus_we = 1; bus_addr = 7'h1C; bus_wdata = '1;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
    rd(32'h1C, d); chk("R7 set wins over clear", d, b & ~a);
    rd(32'h24, d); chk("R5 fall", d, a & ~b);
    rd(32'h2C, d); chk("R4 high sticky", d, a | b);
    rd(32'h34, d); chk("R4 low sticky", d, ~a | ~b);
    wr(32'h18, m); wr(32'h20, ~m);
    @(negedge clk); chk("R8 irq rise/fall", irq, ((b & ~a) & m) | ((a & ~b) & ~m));
    wr(32'h28, m ^ 32'h0FF0_F00F);
    @(negedge clk);
    chk("R8 irq with high", irq, ((b & ~a) & m) | ((a & ~b) & ~m) | ((a | b) & (m ^ 32'h0FF0_F00F)));
    wr(32'h18, 0); wr(32'h20, 0); wr(32'h28, 0);
    wr(32'h24, m);
    rd(32'h24, d); chk("R6 partial clear", d, (a & ~b) & ~m);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] ev, evv, oe, pt, xr, pu, ie, lvl;
    #2;
    rd(32'h00, d); chk("R9 value in reset", d, 0);
    rd(32'h34, d); chk("R9 low in reset", d, 0);
    rd(32'h08, d); chk("R9 oen in reset", d, 0);
    chk("R9 irq in reset", irq, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    rd(32'h34, d); chk("R9 low flags after release", d, '1);
    rd(32'h2C, d); chk("R9 high flags after release", d, 0);

    for (int k = 0; k < 128; k++) begin
      for (int i = 0; i < 32; i++) begin
        int c = (k + i) % 128;
        ev[i] = c[0]; evv[i] = c[1]; oe[i] = c[2]; pt[i] = c[3];
        xr[i] = c[4]; pu[i] = c[5]; ie[i] = c[6];
      end
      @(negedge clk); ext_valid = ev; ext_value = evv;
      wr(32'h08, oe); wr(32'h0C, pt); wr(32'h40, xr); wr(32'h10, pu); wr(32'h04, ie);
      lvl = ev ? 32'h0 : 32'h0;
      for (int i = 0; i < 32; i++)
        lvl[i] = ev[i] ? evv[i] : (oe[i] ? (pt[i] ^ xr[i]) : pu[i]);
      chk("R1/R2 pin level", pin_level, lvl);
      chk("R10 short", short_circuit, ev & oe);
      @(negedge clk);
      rd(32'h00, d); chk("R3 sampled value", d, ie & lvl);
    end

    @(negedge clk); ext_valid = '1; ext_value = 0;
    for (int r = 1; r <= 16; r++)
      if (r != 7 && r != 9 && r != 11 && r != 13)
        wr(r * 4, (32'h9E37_79B9 * r) ^ r);
    for (int r = 1; r <= 16; r++)
      if (r != 7 && r != 9 && r != 11 && r != 13) begin
        rd(r * 4, d); chk("R11 readback", d, (32'h9E37_79B9 * r) ^ r);
      end
    wr(32'h00, '1);
    rd(32'h00, d); chk("R3 value not writable", d, 0);
    wr(32'h44, 32'h1234_5678); wr(32'h05, 32'h1234_5678);
    rd(32'h04, d); chk("R12 ignored write", d, 32'h9E37_79B9 ^ 1);
    rd(32'h44, d); chk("R12 read beyond map", d, 0);
    rd(32'h7C, d); chk("R12 read top", d, 0);
    rd(32'h06, d); chk("R12 unaligned read", d, 0);

    wr(32'h08, 0); wr(32'h10, 0); wr(32'h04, '1);
    wr(32'h18, 0); wr(32'h20, 0); wr(32'h28, 0); wr(32'h30, 0);
    edge_case(32'h0, 32'hFFFF_FFFF, 32'hAAAA_5555);
    edge_case(32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF);
    edge_case(32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hF0F0_0F0F);
    for (int j = 1; j <= 6; j++)
      edge_case(32'h1234_5678 * j, {16'hC3A1 * 16'(j), 16'h7E29 ^ 16'(j * 977)}, 32'h3C3C_C3C3 ^ 32'(j));

    wr(32'h30, 32'h0000_00FF); wr(32'h04, 0);
    @(negedge clk); chk("R8 irq low", irq, 32'h0000_00FF);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule